// File: doc/BRIEF.md
# Dual-Path Glitch-Free Clock Root Slice

This block produces one output clock from any of eight input clocks. Two selection paths, A and B, each hold a 3-bit source selector and a clock gate, with an optional pre-divider after the gate. A final two-way mux chooses one path, and a post-divider follows it. Only one path is live at a time. The other path is idle and gated off, so it can be reprogrammed safely.

Software writes a target command on the system clock domain. Each write loads the requested source into the idle path and closes the live path's gate, using a handshake in that path's own clock domain. The final mux then moves, and the gate of the newly loaded path is opened in its own domain. The roles of the two paths swap on every write.

Writing the same source twice leaves both selectors pointing at one live clock. A handshake timeout keeps the slice from locking up when the outgoing source has been stopped upstream. A busy flag covers the whole sequence. A write that arrives while the slice is busy is held and carried out next.

Top module: `clk_root_slice`

## Requirements
- R1: After reset the readback word is 0x1000_0000 and busy is low. This means bit 28 (gate enable) is 1, bits 26:24 (path A source) are 0, bit 20 (live path, 1 = B) is 0 and bits 10:8 (path B source) are 0. The output runs at the rate of input 0.
- R2: A write loads its source into the idle path's selector and toggles bit 20. Bits 18:16 read the live path's pre-divide field and bits 2:0 read the post-divide field. A live path's selector never changes.
- R3: At most one path gate is requested open at any time. After a switch, the output period equals the selected source period times (pre+1) times (post+1).
- R4: Across every switch, no high or low phase of the output is shorter than the shortest source half-period.
- R5: Repeating the current source moves the output to the other path. Afterwards both selector fields hold that source and the output rate is unchanged.
- R6: Busy is high on the cycle after an accepted write. It stays high until the incoming gate is confirmed in its own domain, or the timeout expires.
- R7: A write issued while busy is high is not lost. It is applied after the current switch, and busy stays high until that second switch is done.
- R8: A write with gate bit 0 still swaps paths but leaves both gates closed, so the output has no rising edge. A later write with gate bit 1 restarts the output.
- R9: When the live source is stopped upstream, a switch to another source still completes within ACK_TIMEOUT+24 system cycles. The output then runs from the new source.
- R10: With pre-dividers present, the pre-divide field divides the path clock by field+1. The post-divide field divides the muxed clock by field+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock for the command and readback interface |
| rst_ni | input | 1 | Synchronous active-low reset (input clocks must run during reset) |
| src_clk_i | input | 8 | The eight candidate source clocks |
| wr_en_i | input | 1 | One-cycle strobe that issues a switch command |
| wr_gate_i | input | 1 | Gate enable carried by the command |
| wr_src_i | input | 3 | Requested source index |
| wr_pre_i | input | 3 | Pre-divide field (ratio is value+1) |
| wr_post_i | input | 3 | Post-divide field (ratio is value+1) |
| rd_data_o | output | 32 | Readback word with the fields listed in R1 and R2 |
| busy_o | output | 1 | High while a switch is in progress or a command is held |
| clk_o | output | 1 | Divided, glitch-free output clock |

## Verification
Busy is due high one system cycle after the write strobe. The bench samples it on the falling edge that follows the accepting rising edge. The readback word is due on the first falling edge at which busy is seen low again: a monitor pops the expected word from a queue filled by the write task and compares it at that point. The output clock period is measured only after three output rising edges, so that a partly counted post-divide interval is not taken as the result. Phase widths are watched at every output edge, and the stuck-source case is timed in system cycles from the write to the fall of busy.

// File: rtl/clk_root_pkg.sv
`timescale 1ns/1ps
// Shared constants, readback field positions and types for the clock root slice.
package clk_root_pkg;
    localparam int NUM_SRC  = 8;
    localparam int SEL_W    = $clog2(NUM_SRC);
    localparam int DIV_W    = 3;
    localparam int REG_W    = 32;
    localparam int GATE_BIT = 28;
    localparam int SELA_LSB = 24;
    localparam int LIVE_BIT = 20;
    localparam int PRE_LSB  = 16;
    localparam int SELB_LSB = 8;
    localparam int POST_LSB = 0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLOSE,
        ST_SWAP,
        ST_OPEN
    } sw_state_e;

    typedef struct packed {
        logic             gate;
        logic [SEL_W-1:0] src;
        logic [DIV_W-1:0] pre;
        logic [DIV_W-1:0] post;
    } sw_cmd_t;
endpackage

// File: rtl/clk_root_sync.sv
`timescale 1ns/1ps
// Multi-flop level synchronizer.
// Assumes d_i is a slow level that is held far longer than STAGES clock periods.
module clk_root_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // shift the level through the flop chain
    always_ff @(posedge clk_i) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clk_root_path.sv
`timescale 1ns/1ps
// One selection path: 8:1 source select, gate and optional pulse-swallow pre-divider.
// Every state flop runs on the falling edge of the selected clock, so the AND
// gating only changes while that clock is low. sel_i and pdiv_i may change only
// while the path is gated closed. The reset needs the selected clock to be running.
module clk_root_path #(
    parameter int NUM_SRC     = 8,
    parameter int SEL_W       = 3,
    parameter int DIV_W       = 3,
    parameter bit HAS_PREDIV  = 1'b1,
    parameter int SYNC_STAGES = 2,
    parameter bit RESET_OPEN  = 1'b0
) (
    input  logic [NUM_SRC-1:0] src_clk_i,
    input  logic               rst_ni,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [DIV_W-1:0]   pdiv_i,
    input  logic               req_i,
    output logic               ack_o,
    output logic               gclk_o
);
    logic pclk;
    logic pclk_n;
    logic req_s;
    logic gate_q;
    logic pulse_en;

    assign pclk   = src_clk_i[sel_i];
    assign pclk_n = ~pclk;

    clk_root_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RESET_OPEN)) u_req_sync (
        .clk_i (pclk_n),
        .rst_ni(rst_ni),
        .d_i   (req_i),
        .q_o   (req_s)
    );

    // gate state follows the synchronized request on the falling edge
    always_ff @(posedge pclk_n) begin
        if (!rst_ni) gate_q <= RESET_OPEN;
        else         gate_q <= req_s;
    end

    generate
        if (HAS_PREDIV) begin : g_prediv
            logic [DIV_W-1:0] cnt_q;
            // count path clock cycles while open; restart when closed
            always_ff @(posedge pclk_n) begin
                if (!rst_ni || !gate_q)  cnt_q <= '0;
                else if (cnt_q >= pdiv_i) cnt_q <= '0;
                else                      cnt_q <= cnt_q + 1'b1;
            end
            assign pulse_en = gate_q && (cnt_q == '0);
        end else begin : g_nodiv
            assign pulse_en = gate_q;
        end
    endgenerate

    assign ack_o  = gate_q;
    assign gclk_o = pclk & pulse_en;
endmodule

// File: rtl/clk_root_postdiv.sv
`timescale 1ns/1ps
// Pulse-swallow post-divider: passes one input high phase out of every div_i+1.
// The enable flop runs on the falling edge, so no pulse is ever shortened.
// A change of div_i may stretch or shorten one interval, never a phase.
module clk_root_postdiv #(
    parameter int DIV_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    output logic             clk_o
);
    logic             clk_n;
    logic [DIV_W-1:0] cnt_q;

    assign clk_n = ~clk_i;

    // count incoming pulses and wrap at the divide limit
    always_ff @(posedge clk_n) begin
        if (!rst_ni)             cnt_q <= '0;
        else if (cnt_q >= div_i) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign clk_o = clk_i & (cnt_q == '0);
endmodule

// File: rtl/clk_root_ctrl.sv
`timescale 1ns/1ps
// System-domain sequencer: accepts commands, alternates the paths, runs the
// close-swap-open handshake with a timeout, holds one command while busy, and
// builds the readback word. The path acknowledges are asynchronous and are
// synchronized here.
module clk_root_ctrl
    import clk_root_pkg::*;
#(
    parameter bit HAS_PREDIV  = 1'b1,
    parameter int ACK_TIMEOUT = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_en_i,
    input  sw_cmd_t               wr_cmd_i,
    input  logic [1:0]            ack_i,
    output logic [1:0]            req_o,
    output logic [1:0][SEL_W-1:0] sel_o,
    output logic [1:0][DIV_W-1:0] pdiv_o,
    output logic [DIV_W-1:0]      post_o,
    output logic                  mux_sel_o,
    output logic                  busy_o,
    output logic [REG_W-1:0]      rd_data_o
);
    localparam int TMO_W = $clog2(ACK_TIMEOUT + 1);

    sw_state_e             state_q;
    logic [1:0]            ack_s;
    logic [1:0]            req_q;
    logic [1:0][SEL_W-1:0] sel_q;
    logic [1:0][DIV_W-1:0] pdiv_q;
    logic [DIV_W-1:0]      post_q;
    logic                  live_q;
    logic                  mux_q;
    logic                  gate_q;
    logic [TMO_W-1:0]      tmo_q;
    logic                  pend_v_q;
    sw_cmd_t               pend_q;
    sw_cmd_t               take;
    logic                  tmo_hit;

    generate
        for (genvar p = 0; p < 2; p++) begin : g_ack
            clk_root_sync #(.STAGES(SYNC_STAGES), .RST_VAL(p == 0)) u_ack_sync (
                .clk_i (clk_i),
                .rst_ni(rst_ni),
                .d_i   (ack_i[p]),
                .q_o   (ack_s[p])
            );
        end
    endgenerate

    // pick the held command first, otherwise the incoming one
    always_comb begin
        take = pend_v_q ? pend_q : wr_cmd_i;
        if (!HAS_PREDIV) take.pre = '0;
    end

    assign tmo_hit = (tmo_q == TMO_W'(ACK_TIMEOUT));

    // switch sequencer with command holding slot
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q  <= ST_IDLE;
            req_q    <= 2'b01;
            sel_q    <= '0;
            pdiv_q   <= '0;
            post_q   <= '0;
            live_q   <= 1'b0;
            mux_q    <= 1'b0;
            gate_q   <= 1'b1;
            tmo_q    <= '0;
            pend_v_q <= 1'b0;
            pend_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (pend_v_q || wr_en_i) begin
                        sel_q[~live_q]  <= take.src;
                        pdiv_q[~live_q] <= take.pre;
                        post_q          <= take.post;
                        gate_q          <= take.gate;
                        live_q          <= ~live_q;
                        req_q[live_q]   <= 1'b0;
                        tmo_q           <= '0;
                        state_q         <= ST_CLOSE;
                        if (pend_v_q) begin
                            pend_v_q <= wr_en_i;
                            pend_q   <= wr_cmd_i;
                        end
                    end
                end
                ST_CLOSE: begin
                    if (!ack_s[mux_q] || tmo_hit) begin
                        tmo_q   <= '0;
                        state_q <= ST_SWAP;
                    end else begin
                        tmo_q <= tmo_q + 1'b1;
                    end
                end
                ST_SWAP: begin
                    mux_q         <= live_q;
                    req_q[live_q] <= gate_q;
                    state_q       <= ST_OPEN;
                end
                default: begin
                    if ((ack_s[live_q] == req_q[live_q]) || tmo_hit) begin
                        tmo_q   <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        tmo_q <= tmo_q + 1'b1;
                    end
                end
            endcase
            if (state_q != ST_IDLE && wr_en_i) begin
                pend_v_q <= 1'b1;
                pend_q   <= wr_cmd_i;
            end
        end
    end

    // readback word assembly
    always_comb begin
        rd_data_o = '0;
        rd_data_o[GATE_BIT]                   = gate_q;
        rd_data_o[SELA_LSB +: SEL_W]          = sel_q[0];
        rd_data_o[LIVE_BIT]                   = live_q;
        rd_data_o[PRE_LSB +: DIV_W]           = pdiv_q[live_q];
        rd_data_o[SELB_LSB +: SEL_W]          = sel_q[1];
        rd_data_o[POST_LSB +: DIV_W]          = post_q;
    end

    assign req_o     = req_q;
    assign sel_o     = sel_q;
    assign pdiv_o    = pdiv_q;
    assign post_o    = post_q;
    assign mux_sel_o = mux_q;
    assign busy_o    = (state_q != ST_IDLE) || pend_v_q;
endmodule

// File: rtl/clk_root_slice.sv
`timescale 1ns/1ps
// Clock root slice top: two alternating selection paths, a final path mux and a
// post-divider. The final mux moves only while both path gates are requested
// closed. All input clocks must run while rst_ni is low.
module clk_root_slice
    import clk_root_pkg::*;
#(
    parameter bit HAS_PREDIV  = 1'b1,
    parameter int ACK_TIMEOUT = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [7:0]       src_clk_i,
    input  logic             wr_en_i,
    input  logic             wr_gate_i,
    input  logic [2:0]       wr_src_i,
    input  logic [2:0]       wr_pre_i,
    input  logic [2:0]       wr_post_i,
    output logic [31:0]      rd_data_o,
    output logic             busy_o,
    output logic             clk_o
);
    sw_cmd_t               cmd_w;
    logic [1:0]            req_w;
    logic [1:0]            ack_w;
    logic [1:0]            gclk_w;
    logic [1:0][SEL_W-1:0] sel_w;
    logic [1:0][DIV_W-1:0] pdiv_w;
    logic [DIV_W-1:0]      post_w;
    logic                  mux_sel_w;
    logic                  clk_mux;

    assign cmd_w = '{gate: wr_gate_i, src: wr_src_i, pre: wr_pre_i, post: wr_post_i};

    clk_root_ctrl #(
        .HAS_PREDIV (HAS_PREDIV),
        .ACK_TIMEOUT(ACK_TIMEOUT),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_cmd_i (cmd_w),
        .ack_i    (ack_w),
        .req_o    (req_w),
        .sel_o    (sel_w),
        .pdiv_o   (pdiv_w),
        .post_o   (post_w),
        .mux_sel_o(mux_sel_w),
        .busy_o   (busy_o),
        .rd_data_o(rd_data_o)
    );

    generate
        for (genvar p = 0; p < 2; p++) begin : g_path
            clk_root_path #(
                .NUM_SRC    (NUM_SRC),
                .SEL_W      (SEL_W),
                .DIV_W      (DIV_W),
                .HAS_PREDIV (HAS_PREDIV),
                .SYNC_STAGES(SYNC_STAGES),
                .RESET_OPEN (p == 0)
            ) u_path (
                .src_clk_i(src_clk_i),
                .rst_ni   (rst_ni),
                .sel_i    (sel_w[p]),
                .pdiv_i   (pdiv_w[p]),
                .req_i    (req_w[p]),
                .ack_o    (ack_w[p]),
                .gclk_o   (gclk_w[p])
            );
        end
    endgenerate

    assign clk_mux = mux_sel_w ? gclk_w[1] : gclk_w[0];

    clk_root_postdiv #(.DIV_W(DIV_W)) u_post (
        .clk_i (clk_mux),
        .rst_ni(rst_ni),
        .div_i (post_w),
        .clk_o (clk_o)
    );
endmodule

// File: rtl/clk_root_chk.sv
`timescale 1ns/1ps
// Assertion checker for the clock root slice, attached by bind below.
module clk_root_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       wr_en_i,
    input logic       busy,
    input logic       mux_sel,
    input logic [1:0] req,
    input logic [2:0] sel_a,
    input logic [2:0] sel_b
);
    // R3: never two gates requested open
    a_r3_single_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req[0] && req[1]));

    // R4: the final mux moves only while both gates were requested closed
    a_r4_mux_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(mux_sel) |-> ($past(req) == 2'b00));

    // R2: the selector of the path on the mux never changes
    a_r2_live_sel_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sel_a) |-> mux_sel);
    a_r2_live_sel_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sel_b) |-> !mux_sel);

    // R6: an accepted write raises busy on the next cycle
    a_r6_busy_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !busy) |=> busy);

    // R7: a write during busy keeps busy high
    a_r7_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && busy) |=> busy);
endmodule

bind clk_root_slice clk_root_chk u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .busy   (busy_o),
    .mux_sel(mux_sel_w),
    .req    (req_w),
    .sel_a  (sel_w[0]),
    .sel_b  (sel_w[1])
);

// File: tb/clk_root_slice_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the write task queues expected readback words, the monitor
// pops one at each fall of busy and compares it.
module clk_root_slice_test;
    localparam int ACK_TIMEOUT = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src = '0;
    logic [7:0]  run = '1;
    logic        wr_en = 1'b0, wr_gate = 1'b0;
    logic [2:0]  wr_src = '0, wr_pre = '0, wr_post = '0;
    logic [31:0] rd_data;
    logic        busy;
    logic        clk_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];

    // reference model state
    logic [2:0] m_sel[2];
    logic [2:0] m_pre[2];
    logic       m_live;
    logic       m_gate;
    logic [2:0] m_post;

    clk_root_slice #(.ACK_TIMEOUT(ACK_TIMEOUT)) uut (
        .clk_i(clk), .rst_ni(rst_n), .src_clk_i(src), .wr_en_i(wr_en),
        .wr_gate_i(wr_gate), .wr_src_i(wr_src), .wr_pre_i(wr_pre),
        .wr_post_i(wr_post), .rd_data_o(rd_data), .busy_o(busy), .clk_o(clk_o)
    );

    always #4 clk = ~clk;

    for (genvar k = 0; k < 8; k++) begin : g_src
        initial begin
            forever begin
                #(5.0 + k);
                if (run[k] || src[k]) src[k] = ~src[k];
            end
        end
    end

    task automatic chk_word(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
        end
    endtask

    task automatic chk_real(string tag, string what, real act, real exp);
        checks++;
        if (act - exp > 0.01 || exp - act > 0.01) begin
            errors++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_word();
        logic [31:0] w = '0;
        w[28]    = m_gate;
        w[26:24] = m_sel[0];
        w[20]    = m_live;
        w[18:16] = m_pre[m_live];
        w[10:8]  = m_sel[1];
        w[2:0]   = m_post;
        return w;
    endfunction

    // driver: one command strobe, model update, optional queued expectation
    task automatic do_write(logic [2:0] s, logic [2:0] pre, logic [2:0] post,
                            logic g, bit push);
        m_sel[~m_live] = s;
        m_pre[~m_live] = pre;
        m_live = ~m_live;
        m_gate = g;
        m_post = post;
        if (push) exp_q.push_back(model_word());
        @(negedge clk);
        wr_en = 1'b1; wr_src = s; wr_pre = pre; wr_post = post; wr_gate = g;
        @(negedge clk);
        wr_en = 1'b0;
        chk_word("R6", "busy after write", {31'b0, busy}, 32'd1);
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy) begin
            @(negedge clk);
            cyc++;
        end
        @(negedge clk);
    endtask

    task automatic meas_period(string tag, real exp);
        realtime t0;
        repeat (3) @(posedge clk_o);
        t0 = $realtime;
        @(posedge clk_o);
        chk_real(tag, "output period ns", $realtime - t0, exp);
    endtask

    // monitor: compare readback on each completion
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && prev && !busy) begin
                if (exp_q.size() == 0)
                    chk_word("R6", "unexpected completion", 32'd1, 32'd0);
                else
                    chk_word("R2", "readback at completion", rd_data, exp_q.pop_front());
            end
            prev = busy;
        end
    end

    // phase width watch for glitches
    bit      mon_on = 1'b0;
    bit      have_last = 1'b0;
    realtime last_t;
    int      short_phases = 0;
    int      rises = 0;
    always @(clk_o) begin
        if (mon_on) begin
            if (have_last && ($realtime - last_t) < 4.9) short_phases++;
            last_t = $realtime;
            have_last = 1'b1;
        end
    end
    always @(posedge clk_o) rises++;

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int cyc;
        int r0;
        m_sel[0] = 0; m_sel[1] = 0; m_pre[0] = 0; m_pre[1] = 0;
        m_live = 0; m_gate = 1; m_post = 0;
        repeat (20) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        // R1 reset state
        chk_word("R1", "reset readback", rd_data, 32'h1000_0000);
        chk_word("R1", "reset busy", {31'b0, busy}, 32'd0);
        meas_period("R1", 10.0);

        // R2/R3 plain switch to input 3
        do_write(3, 0, 0, 1, 1);
        wait_idle(cyc);
        meas_period("R3", 16.0);

        // R5 repeat of the same source
        do_write(3, 0, 0, 1, 1);
        wait_idle(cyc);
        chk_word("R5", "both selectors", {29'b0, rd_data[26:24]}, {29'b0, rd_data[10:8]});
        meas_period("R5", 16.0);

        // R10 dividers: input 5, pre 1, post 2
        do_write(5, 1, 2, 1, 1);
        wait_idle(cyc);
        meas_period("R10", 120.0);

        // R7 second write issued while busy
        do_write(1, 0, 0, 1, 0);
        do_write(6, 0, 0, 1, 1);
        wait_idle(cyc);
        meas_period("R7", 22.0);

        // R8 gate off, then back on
        do_write(6, 0, 0, 0, 1);
        wait_idle(cyc);
        r0 = rises;
        #300;
        chk_word("R8", "rising edges while gated", rises - r0, 0);
        do_write(2, 0, 0, 1, 1);
        wait_idle(cyc);
        meas_period("R8", 14.0);

        // R9 live source stopped upstream, then switch away
        do_write(4, 0, 0, 1, 1);
        wait_idle(cyc);
        meas_period("R3", 18.0);
        run[4] = 1'b0;
        #60;
        do_write(7, 0, 0, 1, 1);
        wait_idle(cyc);
        checks++;
        if (cyc + 2 > ACK_TIMEOUT + 24) begin
            errors++;
            $display("FAIL R9 cycles to completion: actual %0d expected <= %0d",
                     cyc + 2, ACK_TIMEOUT + 24);
        end
        meas_period("R9", 24.0);

        chk_word("R2", "pending expectations", exp_q.size(), 0);
        chk_word("R4", "short output phases", short_phases, 0);
        report();
        $finish;
    end
endmodule